// File: doc/BRIEF.md
# Instruction Fetch Segment Router

This block sits between a processor's program counter and its fetch machinery. It owns the fetch program counter. On each fetch request it looks at the top three bits of the counter (the segment) and chooses one of three paths. The fetch goes to the instruction cache, goes out as one uncached word read, or ends in an instruction bus error. The physical address is the counter with its segment bits removed. That address is then resolved against the two places code can live: a mirrored RAM window and a boot ROM window. Any other physical address is a bus error.

Alongside the path choice, the router reports the memory region, the index inside that device, and two cycle costs. The word cost covers an uncached single-word read. The fill cost covers a full line fill, for use when the cache misses. RAM has fixed timing. ROM timing comes from a programmable wait-cycle input, so the same router serves slow and fast boot devices. A good fetch moves the counter forward by one word. A faulting fetch leaves it in place, so the error handler sees the failing address.

Top module: `fetch_seg_router`

## Requirements
- R1: After reset, pcOut equals 0xBFC00000, and outValid, busErr, pathSel, regionSel, wordCost and fillCost are all zero.
- R2: Segment values 0 and 4 (pcOut bits [31:29]) select pathSel = 2'b01 (cached) when the physical address is legal.
- R3: Segment value 5 selects pathSel = 2'b10 (uncached single word) when the physical address is legal.
- R4: Segment values 1, 2, 3, 6 and 7 raise busErr. With busErr raised, pathSel = 2'b00, regionSel = 2'b00, and memIndex, wordCost and fillCost are zero.
- R5: physAddr is bits [28:0] of the fetched counter, for every segment.
- R6: A physical address below 0x00800000 maps to RAM (regionSel = 2'b01), and memIndex is the address modulo 0x200000.
- R7: A physical address from 0x1FC00000 up to but not including 0x1FC80000 maps to ROM (regionSel = 2'b10), and memIndex is the offset from 0x1FC00000.
- R8: Any other physical address raises busErr, even under segment 0, 4 or 5.
- R9: An uncached fetch reports wordCost = 4 for RAM and wordCost = romWait for ROM, with fillCost = 0.
- R10: A cached fetch reports fillCost = 4 for RAM and fillCost = 4 × romWait for ROM, with wordCost = 0.
- R11: A fetch without a fault advances pcOut by 4, and a faulting fetch leaves pcOut unchanged. pcLoad writes pcLoadValue into pcOut. When pcLoad and fetchReq are raised in the same cycle, the load wins and the fetch is dropped.
- R12: All results appear in the cycle after the request. outValid and busErr are single-cycle pulses, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcLoad | input | 1 | Load the fetch counter |
| pcLoadValue | input | 32 | Value to load |
| fetchReq | input | 1 | Fetch at the current counter |
| romWait | input | 8 | ROM word access time in cycles |
| pcOut | output | 32 | Current fetch counter |
| outValid | output | 1 | Pulse: fetch result valid |
| pathSel | output | 2 | 00 none, 01 cached, 10 uncached |
| regionSel | output | 2 | 00 none, 01 RAM, 10 ROM |
| physAddr | output | 29 | Physical fetch address |
| memIndex | output | 21 | Word-aligned index inside the selected device |
| busErr | output | 1 | Pulse: instruction bus error |
| wordCost | output | 10 | Cycles for an uncached word read |
| fillCost | output | 10 | Cycles for a line fill |

## Verification
The bench builds the router with its default parameters: the real 2 MiB RAM mirrored up to 8 MiB, a 512 KiB ROM window, an 8-bit wait input and 4-word lines. Every segment value is crossed with physical offsets on both sides of each region edge, including a mirrored RAM address. This is repeated under three ROM wait values, the largest 255, so the fill cost reaches its widest result. Back-to-back fetches and a load colliding with a fetch cover the counter's advance and hold rules.

// File: rtl/fetch_route_pkg.sv
package fetch_route_pkg;

  typedef enum logic [1:0] {
    PATH_NONE     = 2'b00,
    PATH_CACHED   = 2'b01,
    PATH_UNCACHED = 2'b10
  } path_e;

  typedef enum logic [1:0] {
    REGION_NONE = 2'b00,
    REGION_RAM  = 2'b01,
    REGION_ROM  = 2'b10
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // write the counter from the load value
    logic capture;   // register a fetch result this edge
    logic cached;    // segment chooses the cached path
    logic uncached;  // segment chooses the uncached path
    logic segFault;  // segment is not fetchable
  } ctrl_s;

endpackage

// File: rtl/fetch_route_ctrl.sv
module fetch_route_ctrl
  import fetch_route_pkg::*;
#(
  parameter logic [7:0] CACHED_SEGS   = 8'b0001_0001,
  parameter logic [7:0] UNCACHED_SEGS = 8'b0010_0000
) (
  input  logic       pcLoad,
  input  logic       fetchReq,
  input  logic [2:0] segBits,
  output ctrl_s      strobes
);

  logic isCached;
  logic isUncached;

  always_comb begin
    isCached   = CACHED_SEGS[segBits];
    isUncached = UNCACHED_SEGS[segBits];
    strobes.load     = pcLoad;
    strobes.capture  = fetchReq && !pcLoad;
    strobes.cached   = isCached;
    strobes.uncached = isUncached && !isCached;
    strobes.segFault = !(isCached || isUncached);
  end

endmodule

// File: rtl/fetch_route_dp.sv
module fetch_route_dp
  import fetch_route_pkg::*;
#(
  parameter int unsigned       WAIT_W          = 8,
  parameter int unsigned       WORDS_PER_LINE  = 4,
  parameter int unsigned       RAM_WORD_COST   = 4,
  parameter int unsigned       RAM_FILL_PER_WD = 1,
  parameter int unsigned       RAM_END         = 32'h0080_0000,
  parameter int unsigned       RAM_SPAN        = 32'h0020_0000,
  parameter int unsigned       ROM_BASE        = 32'h1FC0_0000,
  parameter int unsigned       ROM_SPAN        = 32'h0008_0000,
  parameter logic [31:0]       RESET_PC        = 32'hBFC0_0000,
  parameter int unsigned       FETCH_BYTES     = 4,
  localparam int unsigned      PHYS_W          = 29,
  localparam int unsigned      IDX_W           = $clog2(RAM_SPAN),
  localparam int unsigned      COST_W          = WAIT_W + $clog2(WORDS_PER_LINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_s             strobes,
  input  logic [31:0]       pcLoadValue,
  input  logic [WAIT_W-1:0] romWait,
  output logic [2:0]        segBits,
  output logic [31:0]       pcOut,
  output logic              outValid,
  output logic [1:0]        pathSel,
  output logic [1:0]        regionSel,
  output logic [PHYS_W-1:0] physAddr,
  output logic [IDX_W-1:0]  memIndex,
  output logic              busErr,
  output logic [COST_W-1:0] wordCost,
  output logic [COST_W-1:0] fillCost
);

  localparam logic [PHYS_W-1:0] RAM_END_P  = PHYS_W'(RAM_END);
  localparam logic [PHYS_W-1:0] RAM_MASK_P = PHYS_W'(RAM_SPAN - 1);
  localparam logic [PHYS_W-1:0] ROM_LO_P   = PHYS_W'(ROM_BASE);
  localparam logic [PHYS_W-1:0] ROM_HI_P   = PHYS_W'(ROM_BASE + ROM_SPAN);
  localparam logic [PHYS_W-1:0] ROM_MASK_P = PHYS_W'(ROM_SPAN - 1);
  localparam logic [COST_W-1:0] RAM_WORD_C = COST_W'(RAM_WORD_COST);
  localparam logic [COST_W-1:0] RAM_FILL_C = COST_W'(RAM_FILL_PER_WD * WORDS_PER_LINE);
  localparam logic [COST_W-1:0] LINE_WORDS = COST_W'(WORDS_PER_LINE);

  logic [31:0]       pcReg;
  logic [PHYS_W-1:0] phys;
  logic              inRam;
  logic              inRom;
  logic              fault;
  logic [1:0]        pathNext;
  logic [1:0]        regionNext;
  logic [IDX_W-1:0]  idxNext;
  logic [COST_W-1:0] wordNext;
  logic [COST_W-1:0] fillNext;
  logic [COST_W-1:0] romWaitC;

  assign segBits = pcReg[31:29];
  assign pcOut   = pcReg;

  always_comb begin
    phys     = pcReg[PHYS_W-1:0];
    romWaitC = COST_W'(romWait);
    inRam    = phys < RAM_END_P;
    inRom    = (phys >= ROM_LO_P) && (phys < ROM_HI_P);
    fault    = strobes.segFault || !(inRam || inRom);

    pathNext   = PATH_NONE;
    regionNext = REGION_NONE;
    idxNext    = '0;
    wordNext   = '0;
    fillNext   = '0;
    if (!fault) begin
      pathNext = strobes.cached ? PATH_CACHED : PATH_UNCACHED;
      if (inRam) begin
        regionNext = REGION_RAM;
        idxNext    = IDX_W'(phys & RAM_MASK_P);
      end else begin
        regionNext = REGION_ROM;
        idxNext    = IDX_W'((phys - ROM_LO_P) & ROM_MASK_P);
      end
      if (strobes.uncached) begin
        wordNext = inRam ? RAM_WORD_C : romWaitC;
      end
      if (strobes.cached) begin
        fillNext = inRam ? RAM_FILL_C : COST_W'(romWaitC * LINE_WORDS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcReg     <= RESET_PC;
      outValid  <= 1'b0;
      busErr    <= 1'b0;
      pathSel   <= PATH_NONE;
      regionSel <= REGION_NONE;
      physAddr  <= '0;
      memIndex  <= '0;
      wordCost  <= '0;
      fillCost  <= '0;
    end else begin
      outValid <= strobes.capture;
      busErr   <= strobes.capture && fault;
      if (strobes.load) begin
        pcReg <= pcLoadValue;
      end else if (strobes.capture && !fault) begin
        pcReg <= pcReg + 32'(FETCH_BYTES);
      end
      if (strobes.capture) begin
        pathSel   <= pathNext;
        regionSel <= regionNext;
        physAddr  <= phys;
        memIndex  <= idxNext;
        wordCost  <= wordNext;
        fillCost  <= fillNext;
      end
    end
  end

endmodule

// File: rtl/fetch_seg_router.sv
module fetch_seg_router
  import fetch_route_pkg::*;
#(
  parameter int unsigned  WAIT_W         = 8,
  parameter int unsigned  WORDS_PER_LINE = 4,
  parameter logic [31:0]  RESET_PC       = 32'hBFC0_0000,
  parameter int unsigned  RAM_SPAN       = 32'h0020_0000,
  localparam int unsigned IDX_W          = $clog2(RAM_SPAN),
  localparam int unsigned COST_W         = WAIT_W + $clog2(WORDS_PER_LINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcLoad,
  input  logic [31:0]       pcLoadValue,
  input  logic              fetchReq,
  input  logic [WAIT_W-1:0] romWait,
  output logic [31:0]       pcOut,
  output logic              outValid,
  output logic [1:0]        pathSel,
  output logic [1:0]        regionSel,
  output logic [28:0]       physAddr,
  output logic [IDX_W-1:0]  memIndex,
  output logic              busErr,
  output logic [COST_W-1:0] wordCost,
  output logic [COST_W-1:0] fillCost
);

  ctrl_s      strobes;
  logic [2:0] segBits;

  fetch_route_ctrl u_ctrl (
    .pcLoad   (pcLoad),
    .fetchReq (fetchReq),
    .segBits  (segBits),
    .strobes  (strobes)
  );

  fetch_route_dp #(
    .WAIT_W         (WAIT_W),
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .RAM_SPAN       (RAM_SPAN),
    .RESET_PC       (RESET_PC)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .pcLoadValue (pcLoadValue),
    .romWait     (romWait),
    .segBits     (segBits),
    .pcOut       (pcOut),
    .outValid    (outValid),
    .pathSel     (pathSel),
    .regionSel   (regionSel),
    .physAddr    (physAddr),
    .memIndex    (memIndex),
    .busErr      (busErr),
    .wordCost    (wordCost),
    .fillCost    (fillCost)
  );

endmodule

// File: rtl/fetch_route_chk.sv
module fetch_route_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pcLoad,
  input logic        fetchReq,
  input logic [31:0] pcOut,
  input logic        outValid,
  input logic [1:0]  pathSel,
  input logic [1:0]  regionSel,
  input logic [28:0] physAddr,
  input logic        busErr,
  input logic [9:0]  wordCost,
  input logic [9:0]  fillCost
);

  // R4: a fault carries no path, region or cost
  a_r4_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> (pathSel == 2'b00 && regionSel == 2'b00 && wordCost == '0 && fillCost == '0));

  // R12: results only follow an accepted request
  a_r12_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(fetchReq && !pcLoad));

  a_r12_err_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> outValid);

  // R11: counter step matches the fault outcome
  a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (pcOut == $past(pcOut) + (busErr ? 32'd0 : 32'd4)));

  // R5: physical address is the low 29 bits of the fetched counter
  a_r5_phys: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (physAddr == $past(pcOut[28:0])));

  // R9 / R10: each path reports only its own cost
  a_r9_uncached_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (pathSel == 2'b10) |-> (fillCost == '0));

  a_r10_cached_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (pathSel == 2'b01) |-> (wordCost == '0));

  a_r9_ram_word_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (pathSel == 2'b10 && regionSel == 2'b01) |-> (wordCost == 10'd4));

endmodule

bind fetch_seg_router fetch_route_chk u_chk (.*);

// File: tb/fetch_seg_router_test.sv
module fetch_seg_router_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pcLoad = 1'b0;
  logic [31:0] pcLoadValue = '0;
  logic        fetchReq = 1'b0;
  logic [7:0]  romWait = 8'd3;
  logic [31:0] pcOut;
  logic        outValid;
  logic [1:0]  pathSel;
  logic [1:0]  regionSel;
  logic [28:0] physAddr;
  logic [20:0] memIndex;
  logic        busErr;
  logic [9:0]  wordCost;
  logic [9:0]  fillCost;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_seg_router uut (
    .clk(clk), .rst_n(rst_n), .pcLoad(pcLoad), .pcLoadValue(pcLoadValue),
    .fetchReq(fetchReq), .romWait(romWait), .pcOut(pcOut), .outValid(outValid),
    .pathSel(pathSel), .regionSel(regionSel), .physAddr(physAddr),
    .memIndex(memIndex), .busErr(busErr), .wordCost(wordCost), .fillCost(fillCost)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic loadPc(input logic [31:0] v);
    @(negedge clk);
    pcLoad = 1'b1; pcLoadValue = v;
    @(negedge clk);
    pcLoad = 1'b0;
  endtask

  // one fetch at the current counter, checked against the map
  task automatic fetchAndCheck;
    logic [31:0] pc0;
    logic [2:0]  seg;
    logic [28:0] ph;
    logic        ram, rom, bad;
    logic [1:0]  ePath, eRegion;
    logic [31:0] eIdx, eWord, eFill;
    pc0 = pcOut;
    seg = pc0[31:29];
    ph  = pc0[28:0];
    ram = ph < 29'h0080_0000;
    rom = (ph >= 29'h1FC0_0000) && (ph < 29'h1FC8_0000);
    bad = !(seg == 3'd0 || seg == 3'd4 || seg == 3'd5) || !(ram || rom);
    ePath = bad ? 2'b00 : ((seg == 3'd5) ? 2'b10 : 2'b01);
    eRegion = bad ? 2'b00 : (ram ? 2'b01 : 2'b10);
    eIdx = bad ? 0 : (ram ? (32'(ph) & 32'h1F_FFFF) : ((32'(ph) - 32'h1FC0_0000) & 32'h7_FFFF));
    eWord = (bad || ePath != 2'b10) ? 0 : (ram ? 4 : 32'(romWait));
    eFill = (bad || ePath != 2'b01) ? 0 : (ram ? 4 : 32'(romWait) * 4);
    fetchReq = 1'b1;
    @(negedge clk);
    fetchReq = 1'b0;
    check("R12", "outValid", 32'(outValid), 1);
    check(bad ? "R4" : "R8", "busErr", 32'(busErr), 32'(bad));
    check(seg == 3'd5 ? "R3" : "R2", "pathSel", 32'(pathSel), 32'(ePath));
    check(rom ? "R7" : "R6", "regionSel", 32'(regionSel), 32'(eRegion));
    check("R5", "physAddr", 32'(physAddr), 32'(ph));
    check(rom ? "R7" : "R6", "memIndex", 32'(memIndex), eIdx);
    check("R9", "wordCost", 32'(wordCost), eWord);
    check("R10", "fillCost", 32'(fillCost), eFill);
    check("R11", "pcOut", pcOut, bad ? pc0 : pc0 + 4);
    @(negedge clk);
    check("R12", "busErr pulse ends", 32'(busErr), 0);
    check("R12", "outValid pulse ends", 32'(outValid), 0);
  endtask

  initial begin
    logic [28:0] offs [9];
    logic [7:0]  waits [3];
    offs[0] = 29'h0000_0000; offs[1] = 29'h001F_FFFC; offs[2] = 29'h0020_0010;
    offs[3] = 29'h007F_FFFC; offs[4] = 29'h0080_0000; offs[5] = 29'h1FBF_FFFC;
    offs[6] = 29'h1FC0_0000; offs[7] = 29'h1FC7_FFFC; offs[8] = 29'h1FC8_0000;
    waits[0] = 8'd1; waits[1] = 8'd7; waits[2] = 8'd255;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pcOut", pcOut, 32'hBFC0_0000);
    check("R1", "outValid", 32'(outValid), 0);
    check("R1", "busErr", 32'(busErr), 0);
    check("R1", "pathSel", 32'(pathSel), 0);
    check("R1", "regionSel", 32'(regionSel), 0);
    check("R1", "costs", 32'({wordCost, fillCost}), 0);
    rst_n = 1'b1;

    // fetch straight from the reset vector (segment 5, ROM)
    @(negedge clk);
    fetchAndCheck();

    for (int w = 0; w < 3; w++) begin
      romWait = waits[w];
      for (int s = 0; s < 8; s++) begin
        for (int o = 0; o < 9; o++) begin
          loadPc({3'(s), offs[o]});
          fetchAndCheck();
        end
      end
    end

    // R11: back-to-back fetches advance by 4 each
    loadPc(32'h8000_0100);
    fetchReq = 1'b1;
    repeat (3) @(negedge clk);
    fetchReq = 1'b0;
    check("R11", "pc after three fetches", pcOut, 32'h8000_010C);

    // R11: load and fetch together, load wins and no result appears
    @(negedge clk);
    pcLoad = 1'b1; pcLoadValue = 32'h0000_0040; fetchReq = 1'b1;
    @(negedge clk);
    pcLoad = 1'b0; fetchReq = 1'b0;
    check("R11", "load wins pc", pcOut, 32'h0000_0040);
    check("R11", "dropped fetch outValid", 32'(outValid), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule